// File: doc/BRIEF.md
# Two-Slot Packet Issue Checker

This block sits in the decode stage of a two-wide, in-order pipeline whose code is scheduled ahead of time. Each cycle it can take in one 64-bit fetch packet that carries two 32-bit instruction words. The word at the lower address must be an ALU or branch operation, and the word at the higher address must be a memory access. Either slot may carry a nop instead.

The block holds the accepted packet in a register and checks that each word matches its slot's role. It then looks for the two dependencies that forwarding cannot hide. The first is a memory word that reads the register written by the ALU word of the same packet. The second is a packet that reads the destination of a load now in EX. From these checks the block issues both slots together, splits the packet over two cycles, holds it for a cycle, or discards it when a slot's role is wrong. A fetch-enable output tells the front end when the packet register will take the next packet.

Top module: `dual_issue_gate`

## Requirements
- R1: While reset is asserted, and after it is released with no packet loaded, both issue enables, `stall` and `slot_err` are low, and `fetch_en` is high.
- R2: Slot 0 is packet bits 31:0 and slot 1 is bits 63:32. Within each word the opcode is bits 31:26, rs is 25:21, rt is 20:16 and rd is 15:11. The opcode selects the class. 0 is register-type: it writes rd and reads rs and rt. 4 and 5 are branches: they read rs and rt and write nothing. Opcodes whose two top bits are 10 are memory accesses. Of these, bit 29 clear is a load, which writes rt and reads rs, and bit 29 set is a store, which reads rs and rt. Any other opcode is immediate ALU: it writes rt and reads rs.
- R3: A memory opcode in slot 0, or a slot 1 word that is neither a memory access nor a nop, raises `slot_err` for that cycle. Neither slot issues, there is no stall, and the packet is dropped (`fetch_en` stays high).
- R4: A legal loaded packet with no hazard issues both slots in the same cycle and keeps `fetch_en` high.
- R5: If slot 1 reads the non-zero register written by slot 0, the packet is split. In the first cycle only `issue_alu` is high, `stall` is high and `fetch_en` is low. In the next cycle that has no hazard, only `issue_mem` is high and `fetch_en` is high.
- R6: When `ex_is_load` is high and a source of a slot still waiting to issue equals the non-zero `ex_dst`, no slot issues, `stall` is high, `fetch_en` is low and the packet is kept. During the second half of a split packet, only slot 1's sources are compared.
- R7: Register 0 never creates a dependency, whether it is a source, a destination or `ex_dst`.
- R8: When `ex_is_load` is low, the packet is never stalled, whatever `ex_dst` holds.
- R9: With no valid packet loaded, no slot issues and `fetch_en` is high. The register loads `pkt_in`/`pkt_vld` only on edges where `fetch_en` is high.
- R10: The all-zero word is a nop and is legal in either slot. A packet with a nop in one slot issues like any other legal packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_in | input | 64 | Fetch packet offered for the next load |
| pkt_vld | input | 1 | `pkt_in` holds a real packet |
| ex_dst | input | 5 | Destination register of the instruction in EX |
| ex_is_load | input | 1 | The instruction in EX is a load |
| issue_alu | output | 1 | Slot 0 issues this cycle |
| issue_mem | output | 1 | Slot 1 issues this cycle |
| stall | output | 1 | Packet held in decode this cycle |
| slot_err | output | 1 | Loaded packet breaks the slot roles |
| fetch_en | output | 1 | Packet register loads on the next edge |

## Verification
The bench concentrates on split packets followed by a load-use hazard in their second cycle. A design that rechecks slot 0 there would stall for nothing, and one that forgets the phase would issue slot 0 twice. It also covers dependencies through register 0 and `ex_dst` of zero, which a careless comparator turns into spurious splits or stalls. Further corners are a wrong role in each slot, where a design that still issues or holds the packet shows up at once, and EX results from non-load instructions, which must never stall. Randomised packets draw from a small register pool so that matches are frequent, with valid gaps in between.

// File: rtl/dig_pkg.sv
package dig_pkg;
  localparam int unsigned IW  = 32;
  localparam int unsigned PW  = 2 * IW;
  localparam int unsigned RW  = 5;
  localparam int unsigned OPW = 6;
  localparam int unsigned OP_LSB = IW - OPW;
  localparam int unsigned RS_LSB = OP_LSB - RW;
  localparam int unsigned RT_LSB = RS_LSB - RW;
  localparam int unsigned RD_LSB = RT_LSB - RW;

  typedef struct packed {
    logic          role_ok;
    logic          wr_en;
    logic [RW-1:0] wr_reg;
    logic          ra_en;
    logic [RW-1:0] ra;
    logic          rb_en;
    logic [RW-1:0] rb;
  } slot_info_t;
endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import dig_pkg::*;
#(
  parameter int unsigned SLOT = 0
) (
  input  logic [IW-1:0] word,
  output slot_info_t    info
);
  logic [OPW-1:0] op;
  logic [RW-1:0]  f_rs, f_rt, f_rd;
  logic           is_nop, is_mem, is_store, is_rtype, is_branch;

  always_comb begin
    op        = word[IW-1:OP_LSB];
    f_rs      = word[OP_LSB-1:RS_LSB];
    f_rt      = word[RS_LSB-1:RT_LSB];
    f_rd      = word[RT_LSB-1:RD_LSB];
    is_nop    = (word == '0);
    is_mem    = (op[OPW-1:OPW-2] == 2'b10);
    is_store  = is_mem & op[OPW-3];
    is_rtype  = (op == '0);
    is_branch = (op[OPW-1:1] == 5'b00010);
  end

  always_comb begin
    info.ra    = f_rs;
    info.rb    = f_rt;
    info.ra_en = 1'b1;
    info.rb_en = is_rtype | is_branch | is_store;
    info.wr_en = ~(is_branch | is_store);
    info.wr_reg = is_rtype ? f_rd : f_rt;
  end

  generate
    if (SLOT == 0) begin : g_alu_slot
      logic unused_nop;
      assign unused_nop   = is_nop;
      assign info.role_ok = ~is_mem;
    end else begin : g_mem_slot
      assign info.role_ok = is_mem | is_nop;
    end
  endgenerate
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import dig_pkg::*;
(
  input  slot_info_t    info0,
  input  slot_info_t    info1,
  input  logic          phase,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_is_load,
  output logic          role_err,
  output logic          pair_dep,
  output logic          ld_use
);
  function automatic logic reads_reg(input slot_info_t s, input logic [RW-1:0] r);
    return (r != '0) && ((s.ra_en && s.ra == r) || (s.rb_en && s.rb == r));
  endfunction

  logic hit0, hit1;
  logic unused_s1;

  assign unused_s1 = ^{info1.wr_en, info1.wr_reg};

  always_comb begin
    role_err = ~info0.role_ok | ~info1.role_ok;
    pair_dep = info0.wr_en && reads_reg(info1, info0.wr_reg);
    hit0     = ex_is_load && reads_reg(info0, ex_dst);
    hit1     = ex_is_load && reads_reg(info1, ex_dst);
    ld_use   = hit1 | (hit0 & ~phase);
  end
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import dig_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pkt_in,
  input  logic          pkt_vld,
  input  logic          role_err,
  input  logic          pair_dep,
  input  logic          ld_use,
  output logic [PW-1:0] pkt_q,
  output logic          phase_q,
  output logic          issue_alu,
  output logic          issue_mem,
  output logic          stall,
  output logic          slot_err,
  output logic          fetch_en
);
  logic vld_q;
  logic phase_d;

  always_comb begin
    issue_alu = 1'b0;
    issue_mem = 1'b0;
    stall     = 1'b0;
    slot_err  = 1'b0;
    phase_d   = phase_q;
    if (vld_q) begin
      if (role_err && !phase_q) begin
        slot_err = 1'b1;
      end else if (ld_use) begin
        stall = 1'b1;
      end else if (phase_q) begin
        issue_mem = 1'b1;
        phase_d   = 1'b0;
      end else if (pair_dep) begin
        issue_alu = 1'b1;
        stall     = 1'b1;
        phase_d   = 1'b1;
      end else begin
        issue_alu = 1'b1;
        issue_mem = 1'b1;
      end
    end
    fetch_en = ~stall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (fetch_en) vld_q <= pkt_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch_en) pkt_q <= pkt_in;
  end
endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
  import dig_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pkt_in,
  input  logic          pkt_vld,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_is_load,
  output logic          issue_alu,
  output logic          issue_mem,
  output logic          stall,
  output logic          slot_err,
  output logic          fetch_en
);
  logic [PW-1:0] pkt_q;
  logic          phase_q;
  slot_info_t    info [2];
  logic          role_err, pair_dep, ld_use;

  generate
    for (genvar s = 0; s < 2; s++) begin : g_slot
      slot_decode #(.SLOT(s)) u_dec (
        .word (pkt_q[s*IW +: IW]),
        .info (info[s])
      );
    end
  endgenerate

  hazard_unit u_haz (
    .info0      (info[0]),
    .info1      (info[1]),
    .phase      (phase_q),
    .ex_dst     (ex_dst),
    .ex_is_load (ex_is_load),
    .role_err   (role_err),
    .pair_dep   (pair_dep),
    .ld_use     (ld_use)
  );

  issue_ctrl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_in    (pkt_in),
    .pkt_vld   (pkt_vld),
    .role_err  (role_err),
    .pair_dep  (pair_dep),
    .ld_use    (ld_use),
    .pkt_q     (pkt_q),
    .phase_q   (phase_q),
    .issue_alu (issue_alu),
    .issue_mem (issue_mem),
    .stall     (stall),
    .slot_err  (slot_err),
    .fetch_en  (fetch_en)
  );
endmodule

// File: rtl/dual_issue_gate_chk.sv
module dual_issue_gate_chk
  import dig_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          ex_is_load,
  input logic          issue_alu,
  input logic          issue_mem,
  input logic          stall,
  input logic          slot_err,
  input logic          fetch_en,
  input logic          phase_q,
  input logic [PW-1:0] pkt_q
);
  AST_ERR_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_err |-> (!issue_alu && !issue_mem && !stall)); // R3

  AST_SPLIT_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_alu && !issue_mem) |=> (!issue_alu && phase_q)); // R5

  AST_HOLD_KEEPS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> $stable(pkt_q)); // R6

  AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !fetch_en); // R6

  AST_NONLOAD_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_is_load && !phase_q) |-> (!stall || (issue_alu && !issue_mem))); // R8

  AST_ERR_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> !slot_err); // R3
endmodule

bind dual_issue_gate dual_issue_gate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ex_is_load (ex_is_load),
  .issue_alu  (issue_alu),
  .issue_mem  (issue_mem),
  .stall      (stall),
  .slot_err   (slot_err),
  .fetch_en   (fetch_en),
  .phase_q    (phase_q),
  .pkt_q      (pkt_q)
);

// File: tb/dual_issue_gate_test.sv
`timescale 1ns/1ps
module dual_issue_gate_test;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pkt_in = '0;
  logic        pkt_vld = 1'b0;
  logic [4:0]  ex_dst = '0;
  logic        ex_is_load = 1'b0;
  logic        issue_alu, issue_mem, stall, slot_err, fetch_en;

  int nvec = 0;
  int nbad = 0;

  logic [63:0] m_pkt = '0;
  logic        m_vld = 1'b0;
  logic        m_phase = 1'b0;
  string       m_tag = "";
  logic        accepted;

  always #(CLK_NS/2) clk = ~clk;

  dual_issue_gate uut (
    .clk(clk), .rst_n(rst_n), .pkt_in(pkt_in), .pkt_vld(pkt_vld),
    .ex_dst(ex_dst), .ex_is_load(ex_is_load),
    .issue_alu(issue_alu), .issue_mem(issue_mem), .stall(stall),
    .slot_err(slot_err), .fetch_en(fetch_en)
  );

  // encoders (R2 field layout)
  function automatic logic [31:0] rtype(input int rd, input int rs, input int rt);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 11'd0};
  endfunction
  function automatic logic [31:0] addi(input int rt, input int rs);
    return {6'h08, rs[4:0], rt[4:0], 16'h0004};
  endfunction
  function automatic logic [31:0] beq(input int rs, input int rt);
    return {6'h04, rs[4:0], rt[4:0], 16'h0001};
  endfunction
  function automatic logic [31:0] lw(input int rt, input int rs);
    return {6'h23, rs[4:0], rt[4:0], 16'h0000};
  endfunction
  function automatic logic [31:0] sw(input int rt, input int rs);
    return {6'h2b, rs[4:0], rt[4:0], 16'h0008};
  endfunction
  function automatic logic [63:0] pk(input logic [31:0] a, input logic [31:0] m);
    return {m, a};
  endfunction

  // reference model of R2 classes
  function automatic bit is_ldst(input logic [31:0] w);
    return w[31:30] == 2'b10;
  endfunction
  function automatic bit reads(input logic [31:0] w, input logic [4:0] r);
    logic [5:0] op = w[31:26];
    bit two = (op == 0) || (op == 4) || (op == 5) || (is_ldst(w) && op[3]);
    if (r == 0) return 0;
    return (w[25:21] == r) || (two && w[20:16] == r);
  endfunction
  function automatic logic [4:0] dest(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    if (op == 0) return w[15:11];
    if (op == 4 || op == 5) return 0;
    if (is_ldst(w)) return op[3] ? 5'd0 : w[20:16];
    return w[20:16];
  endfunction

  task automatic cycle(input logic [63:0] p, input logic pv, input logic [4:0] ed,
                       input logic el, input string tag);
    logic [31:0] s0, s1;
    logic e_alu, e_mem, e_st, e_err, n_phase;
    string t;
    @(negedge clk);
    pkt_in = p; pkt_vld = pv; ex_dst = ed; ex_is_load = el;
    #2;
    s0 = m_pkt[31:0]; s1 = m_pkt[63:32];
    e_alu = 0; e_mem = 0; e_st = 0; e_err = 0; n_phase = m_phase;
    t = "R9";
    if (m_vld) begin
      if (!m_phase && (is_ldst(s0) || (!is_ldst(s1) && s1 != 0))) begin
        e_err = 1; t = "R3";
      end else if (el && ((reads(s1, ed)) || (!m_phase && reads(s0, ed)))) begin
        e_st = 1; t = "R6";
      end else if (m_phase) begin
        e_mem = 1; n_phase = 0; t = "R5";
      end else if (dest(s0) != 0 && reads(s1, dest(s0))) begin
        e_alu = 1; e_st = 1; n_phase = 1; t = "R5";
      end else begin
        e_alu = 1; e_mem = 1; t = "R4";
      end
      if (m_tag != "" && t != "R6" && t != "R3") t = m_tag;
      if (m_tag == "R3" || m_tag == "R6") t = m_tag;
    end
    nvec++;
    if ({issue_alu, issue_mem, stall, slot_err, fetch_en} !== {e_alu, e_mem, e_st, e_err, !e_st}) begin
      nbad++;
      $display("FAIL %s: alu/mem/stall/err/fetch got %b%b%b%b%b exp %b%b%b%b%b", t,
               issue_alu, issue_mem, stall, slot_err, fetch_en, e_alu, e_mem, e_st, e_err, !e_st);
    end
    accepted = !e_st;
    m_phase = n_phase;
    if (!e_st) begin m_pkt = p; m_vld = pv; m_tag = tag; end
  endtask

  task automatic offer(input logic [63:0] p, input logic pv, input logic [4:0] ed,
                       input logic el, input string tag);
    bit first = 1;
    do begin
      cycle(p, pv, first ? ed : 5'd0, first ? el : 1'b0, tag);
      first = 0;
    end while (!accepted);
  endtask

  function automatic int rreg();
    return ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 3));
  endfunction
  function automatic logic [31:0] rslot0();
    case ($urandom_range(0, 9))
      0: return 32'h0;
      1, 2, 3: return rtype(rreg(), rreg(), rreg());
      4, 5, 6: return addi(rreg(), rreg());
      7, 8: return beq(rreg(), rreg());
      default: return lw(rreg(), rreg());
    endcase
  endfunction
  function automatic logic [31:0] rslot1();
    case ($urandom_range(0, 9))
      0: return 32'h0;
      1, 2, 3, 4: return lw(rreg(), rreg());
      5, 6, 7, 8: return sw(rreg(), rreg());
      default: return addi(rreg(), rreg());
    endcase
  endfunction

  initial begin
    #(CLK_NS * 200000);
    nbad++;
    $display("FAIL watchdog: run did not finish, got hang exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    nvec++;
    if ({issue_alu, issue_mem, stall, slot_err, fetch_en} !== 5'b00001) begin
      nbad++;
      $display("FAIL R1: outputs in reset got %b%b%b%b%b exp 00001",
               issue_alu, issue_mem, stall, slot_err, fetch_en);
    end
    rst_n = 1'b1;
    cycle('0, 1'b0, 5'd0, 1'b0, "R1");
    cycle('0, 1'b0, 5'd0, 1'b0, "R1");

    offer(pk(rtype(3, 1, 2), lw(4, 5)), 1, 0, 0, "R4");
    offer(pk(addi(6, 1), sw(6, 7)), 1, 0, 0, "R5");
    offer(pk(32'h0, lw(8, 9)), 1, 0, 0, "R10");
    offer(pk(addi(0, 1), sw(0, 2)), 1, 0, 0, "R7");
    offer(pk(rtype(10, 8, 1), 32'h0), 1, 8, 1, "R6");
    offer(pk(rtype(11, 12, 13), lw(1, 14)), 1, 8, 1, "R6");
    offer(pk(addi(15, 2), sw(3, 4)), 1, 14, 1, "R8");
    offer(pk(rtype(18, 0, 0), sw(0, 0)), 1, 2, 0, "R7");
    offer(pk(lw(1, 2), lw(3, 4)), 1, 0, 1, "R3");
    offer(pk(addi(1, 2), addi(3, 4)), 1, 0, 0, "R3");
    offer(pk(addi(5, 6), sw(5, 6)), 1, 0, 0, "R5");
    offer(pk(addi(7, 7), 32'h0), 0, 5, 1, "R9");
    offer(pk(32'h0, 32'h0), 1, 0, 0, "R10");
    offer(pk(32'h0, 32'h0), 0, 0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      cycle(pk(rslot0(), rslot1()), ($urandom_range(0, 4) != 0),
            5'(rreg()), ($urandom_range(0, 2) == 0), "");
    end
    cycle('0, 1'b0, 5'd0, 1'b0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule